// File: doc/BRIEF.md
# Serial Flash Two-Step Software Reset

This block sits on the target side of a serial flash device. It watches a bus framed by chip select, collects one instruction byte per frame and acts on a guarded software reset. The byte arrives either on a single data line (8 clock edges) or on four data lines (2 clock edges). The serial clock may idle low or high. Chip select, serial clock, data lines and the lane-mode select are synchronised into the system clock domain before anything uses them.

A reset needs two steps. An arming opcode comes first, and the reset opcode must follow as the very next complete command. Any other complete command clears the arming, and the caller must then start the pair again. Once a reset is accepted, the block sends a one-cycle clear strobe to the volatile registers elsewhere in the device. It then holds a busy flag for a fixed number of system clock cycles, and every frame that arrives during that time is dropped. Complete commands that are not part of the reset pair are forwarded on a command strobe so that the rest of the device can decode them.

Top module: `flash_swrst`

## Requirements
- R1: In single-line mode (`quad_mode`=0), the opcode is taken from `io_in[0]` on 8 rising serial clock edges while `cs_n` is low, most significant bit first.
- R2: In four-line mode (`quad_mode`=1), the opcode is taken on 2 rising serial clock edges. Each edge carries a nibble with `io_in[3]` as its most significant bit, and the upper nibble comes first.
- R3: A frame counts as complete only if `cs_n` rises after exactly 8 edges (single-line mode) or exactly 2 edges (four-line mode). Any other frame is dropped. It produces no strobe and leaves the armed state unchanged.
- R4: Opcode 0x66 sets the armed state and does not pulse `cmd_valid`.
- R5: Opcode 0x99 received while armed pulses `vol_clear` high for one cycle. In that same cycle `busy` rises and stays high for exactly `RST_CYCLES` system cycles. The armed state is cleared.
- R6: Any complete opcode other than 0x66 or 0x99 clears the armed state and is forwarded through `cmd_valid`/`cmd_code`. A following 0x99 therefore performs no reset.
- R7: Opcode 0x99 received while not armed is forwarded through `cmd_valid` as an ordinary command, and `vol_clear` stays low.
- R8: While `busy` is high, every frame is dropped: no `cmd_valid`, no `vol_clear`, and no arming.
- R9: Serial clock idle-low (mode 0) and idle-high (mode 3) framing both decode the same way.
- R10: After `rst_n` is released, `busy`, `vol_clear` and `cmd_valid` are low and the block is not armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing each instruction |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| io_in | input | 4 | Serial data lines; bit 0 is the single-line input |
| quad_mode | input | 1 | 1 selects four-line opcode transfer |
| busy | output | 1 | High during the reset lockout interval |
| vol_clear | output | 1 | One-cycle strobe that returns volatile registers to power-on values |
| cmd_valid | output | 1 | One-cycle strobe for a forwarded complete command |
| cmd_code | output | 8 | Opcode of the forwarded command, valid with `cmd_valid` |

## Verification
The hardest case to reach from the ports is a frame that lands inside the lockout window. The only other part of that case is the armed state, which has no port of its own. The bench therefore sends a frame at once after an accepted reset, so that it finishes well within `RST_CYCLES`. It also sends an arming opcode during the lockout and follows it with 0x99 after `busy` falls; that 0x99 must come out as an ordinary forwarded command. Random frames mix opcodes, lane modes, clock polarity and an occasional wrong edge count, so that arming is broken and restored in many orders.

// File: rtl/flash_swrst_pkg.sv
package flash_swrst_pkg;
   localparam int unsigned OPW = 8;
   localparam logic [OPW-1:0] OP_ARM  = 8'h66;
   localparam logic [OPW-1:0] OP_KICK = 8'h99;
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_ARM  = 2'd1,
      ACT_KICK = 2'd2,
      ACT_FWD  = 2'd3
   } act_e;
endpackage

// File: rtl/flash_swrst_sync.sv
module flash_swrst_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned LANES  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sck,
   input  logic [LANES-1:0] io_in,
   input  logic             quad_mode,
   output logic             cs_high,
   output logic             cs_rise,
   output logic             sck_rise,
   output logic [LANES-1:0] io_s,
   output logic             quad_s
);
   localparam int unsigned W = LANES + 3;
   localparam logic [W-1:0] RST_VAL = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] stg [STAGES+1];

   if (STAGES < 2) begin : g_bad_stages
      $error("flash_swrst_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= {cs_n, sck, quad_mode, io_in};
   end

   for (genvar k = 1; k <= STAGES; k++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= RST_VAL;
         else        stg[k] <= stg[k-1];
      end
   end

   logic [W-1:0] cur, prv;
   assign cur = stg[STAGES-1];
   assign prv = stg[STAGES];

   assign cs_high  = cur[W-1];
   assign cs_rise  = cur[W-1] & ~prv[W-1];
   assign sck_rise = cur[W-2] & ~prv[W-2] & ~cur[W-1];
   assign quad_s   = cur[W-3];
   assign io_s     = cur[LANES-1:0];
endmodule

// File: rtl/flash_swrst_deser.sv
module flash_swrst_deser #(
   parameter int unsigned OPW   = 8,
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_high,
   input  logic             cs_rise,
   input  logic             sck_rise,
   input  logic [LANES-1:0] io_s,
   input  logic             quad_s,
   output logic             frame_valid,
   output logic [OPW-1:0]   frame_op
);
   localparam int unsigned SPI_LEN = OPW;
   localparam int unsigned QPI_LEN = OPW / LANES;
   localparam int unsigned CW      = $clog2(SPI_LEN + 2);
   localparam logic [CW-1:0] CMAX  = {CW{1'b1}};

   if (OPW % LANES != 0) begin : g_bad_width
      $error("flash_swrst_deser: OPW must be a multiple of LANES");
   end

   logic [CW-1:0]  edges;
   logic [OPW-1:0] shreg;
   logic [OPW-1:0] shnext;

   always_comb begin
      if (quad_s) shnext = {shreg[OPW-LANES-1:0], io_s};
      else        shnext = {shreg[OPW-2:0], io_s[0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges <= '0;
         shreg <= '0;
      end else if (cs_high) begin
         edges <= '0;
      end else if (sck_rise) begin
         shreg <= shnext;
         if (edges != CMAX) edges <= edges + 1'b1;
      end
   end

   logic len_ok;
   assign len_ok = quad_s ? (edges == CW'(QPI_LEN)) : (edges == CW'(SPI_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
         frame_op    <= '0;
      end else begin
         frame_valid <= cs_rise & len_ok;
         if (cs_rise) frame_op <= shreg;
      end
   end

   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);
   p_valid_after_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(cs_rise));
endmodule

// File: rtl/flash_swrst_seq.sv
module flash_swrst_seq
   import flash_swrst_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 3000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_valid,
   input  logic [OPW-1:0] frame_op,
   output logic           busy,
   output logic           vol_clear,
   output logic           cmd_valid,
   output logic [OPW-1:0] cmd_code
);
   localparam int unsigned TW = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 2) begin : g_bad_cycles
      $error("flash_swrst_seq: RST_CYCLES must be at least 2");
   end

   logic          armed;
   logic [TW-1:0] timer;
   act_e          act;

   assign busy = (timer != '0);

   always_comb begin
      act = ACT_NONE;
      if (frame_valid && !busy) begin
         if (frame_op == OP_ARM)                act = ACT_ARM;
         else if (frame_op == OP_KICK && armed) act = ACT_KICK;
         else                                   act = ACT_FWD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         timer     <= '0;
         vol_clear <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
      end else begin
         vol_clear <= 1'b0;
         cmd_valid <= 1'b0;
         if (busy) timer <= timer - 1'b1;
         unique case (act)
            ACT_ARM:  armed <= 1'b1;
            ACT_KICK: begin
               armed     <= 1'b0;
               vol_clear <= 1'b1;
               timer     <= TW'(RST_CYCLES);
            end
            ACT_FWD: begin
               armed     <= 1'b0;
               cmd_valid <= 1'b1;
               cmd_code  <= frame_op;
            end
            default: ;
         endcase
      end
   end

   p_clear_with_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vol_clear |-> busy && !$past(busy));
   p_clear_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vol_clear |=> !vol_clear);
   p_no_cmd_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !cmd_valid);
   p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !busy && frame_op != OP_ARM) |=> !armed);
   p_cmd_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !vol_clear);
endmodule

// File: rtl/flash_swrst.sv
module flash_swrst
   import flash_swrst_pkg::*;
#(
   parameter int unsigned RST_CYCLES  = 3000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_n,
   input  logic           sck,
   input  logic [3:0]     io_in,
   input  logic           quad_mode,
   output logic           busy,
   output logic           vol_clear,
   output logic           cmd_valid,
   output logic [OPW-1:0] cmd_code
);
   localparam int unsigned LANES = 4;

   logic             cs_high, cs_rise, sck_rise, quad_s;
   logic [LANES-1:0] io_s;
   logic             frame_valid;
   logic [OPW-1:0]   frame_op;

   flash_swrst_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io_in(io_in),
      .quad_mode(quad_mode), .cs_high(cs_high), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .io_s(io_s), .quad_s(quad_s));

   flash_swrst_deser #(.OPW(OPW), .LANES(LANES)) u_deser (
      .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .io_s(io_s), .quad_s(quad_s),
      .frame_valid(frame_valid), .frame_op(frame_op));

   flash_swrst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_op(frame_op),
      .busy(busy), .vol_clear(vol_clear), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code));
endmodule

// File: tb/flash_swrst_test.sv
module flash_swrst_test;
   localparam int PERIOD = 10;
   localparam int RSTC   = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic [3:0] io_in = 4'h0;
   logic       quad_mode = 1'b0;
   logic       busy, vol_clear, cmd_valid;
   logic [7:0] cmd_code;

   int errors = 0;
   int checks = 0;
   int n_clear = 0;
   int n_cmd = 0;
   logic [7:0] last_code = 8'h00;
   int run = 0;
   int last_run = 0;
   bit model_armed = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   flash_swrst #(.RST_CYCLES(RSTC)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io_in(io_in),
      .quad_mode(quad_mode), .busy(busy), .vol_clear(vol_clear),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code));

   always @(negedge clk) begin
      if (rst_n) begin
         if (vol_clear) n_clear++;
         if (cmd_valid) begin n_cmd++; last_code = cmd_code; end
         if (busy) run++;
         else if (run != 0) begin last_run = run; run = 0; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] op, input int edges, input bit quad, input bit cpol);
      quad_mode = quad;
      sck = cpol;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < edges; k++) begin
         sck = 1'b0;
         if (quad) io_in = (k < 2) ? op[7-4*k -: 4] : 4'h0;
         else      io_in = {3'b000, (k < 8) ? op[7-k] : 1'b0};
         repeat (4) @(negedge clk);
         sck = 1'b1;
         repeat (4) @(negedge clk);
      end
      if (!cpol) sck = 1'b0;
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   // 0 none, 1 arm, 2 reset, 3 forward
   function automatic int predict(input logic [7:0] op, input bit lenok, input bit armed);
      if (!lenok) return 0;
      if (op == 8'h66) return 1;
      if (op == 8'h99 && armed) return 2;
      return 3;
   endfunction

   task automatic frame_chk(input logic [7:0] op, input int edges, input bit quad,
                            input bit cpol, input string req);
      int c0, v0, outc;
      bit lenok;
      c0 = n_cmd; v0 = n_clear;
      lenok = quad ? (edges == 2) : (edges == 8);
      outc = predict(op, lenok, model_armed);
      send(op, edges, quad, cpol);
      if (outc == 1) model_armed = 1'b1;
      else if (outc != 0) model_armed = 1'b0;
      chk(n_clear - v0 == (outc == 2 ? 1 : 0), req, n_clear - v0, outc == 2 ? 1 : 0);
      chk(n_cmd - c0 == (outc == 3 ? 1 : 0), req, n_cmd - c0, outc == 3 ? 1 : 0);
      if (outc == 3) chk(last_code == op, req, last_code, op);
      if (outc == 2) begin
         chk(busy == 1'b1, req, busy, 1);
         wait (!busy);
         repeat (3) @(negedge clk);
         chk(last_run == RSTC, "R5 busy length", last_run, RSTC);
      end
   endtask

   initial begin
      #(PERIOD * 190000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 0 && vol_clear == 0 && cmd_valid == 0, "R10", {busy, vol_clear, cmd_valid}, 0);
      frame_chk(8'h99, 8, 0, 0, "R10 unarmed after reset");
      // R1 / R6 plain single-line command
      frame_chk(8'hA5, 8, 0, 0, "R1");
      // R2 four-line command
      frame_chk(8'h3C, 2, 1, 0, "R2");
      // R4 + R5 valid pair single-line, mode 0
      frame_chk(8'h66, 8, 0, 0, "R4");
      frame_chk(8'h99, 8, 0, 0, "R5");
      // R9 + R2 valid pair four-line, mode 3
      frame_chk(8'h66, 2, 1, 1, "R9");
      frame_chk(8'h99, 2, 1, 1, "R9");
      // R9 mode 3 single-line command
      frame_chk(8'h5A, 8, 0, 1, "R9 mode3 spi");
      // R6 pair broken by another command
      frame_chk(8'h66, 8, 0, 0, "R6 arm");
      frame_chk(8'h05, 8, 0, 0, "R6 break");
      frame_chk(8'h99, 8, 0, 0, "R6 after break");
      // R7 reset opcode without arming
      frame_chk(8'h99, 2, 1, 0, "R7");
      // R3 short / long frames do not disarm or fire
      frame_chk(8'h66, 8, 0, 0, "R3 arm");
      frame_chk(8'h05, 7, 0, 0, "R3 short");
      frame_chk(8'h05, 3, 1, 1, "R3 long quad");
      frame_chk(8'h99, 9, 0, 0, "R3 long spi");
      frame_chk(8'h99, 8, 0, 0, "R3 arm kept");
      // R8 lockout: frames during busy are dropped
      begin
         int c0, v0;
         send(8'h66, 8, 0, 0);
         send(8'h99, 8, 0, 0);
         chk(busy == 1, "R8 busy", busy, 1);
         c0 = n_cmd; v0 = n_clear;
         send(8'h12, 8, 0, 0);
         send(8'h66, 2, 1, 0);
         chk(busy == 1, "R8 still busy", busy, 1);
         chk(n_cmd == c0, "R8 cmd", n_cmd - c0, 0);
         chk(n_clear == v0, "R8 clear", n_clear - v0, 0);
         wait (!busy);
         repeat (3) @(negedge clk);
         model_armed = 1'b0;
         frame_chk(8'h99, 8, 0, 0, "R8 arm ignored");
      end
      // random mix
      for (int i = 0; i < 60; i++) begin
         logic [7:0] op;
         int sel, edges;
         bit q, p;
         sel = $urandom_range(0, 9);
         op = (sel < 3) ? 8'h66 : (sel < 6) ? 8'h99 : 8'($urandom_range(0, 255));
         q = 1'($urandom_range(0, 1));
         p = 1'($urandom_range(0, 1));
         edges = q ? 2 : 8;
         if ($urandom_range(0, 7) == 0) edges = edges + ($urandom_range(0, 1) ? 1 : -1);
         frame_chk(op, edges, q, p, "R6 random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule